// File: doc/BRIEF.md
# Spanning Tree State Table

This block keeps one spanning-tree port-state record for every value of a 6-bit state identifier. Each record holds a presence flag and a 2-bit forwarding state for each switch port. A host reaches the table through five 16-bit registers: an identifier register, an operation register, a presence register, and two data words. The operation register carries a start/busy bit and a 3-bit opcode.

Two operations exist. The first is load/purge. It either writes the data-word states into the record named by the identifier register, or it clears that record, depending on the presence bit. The second is get-next. It scans upward from the identifier register and returns the first present record with a strictly larger identifier. To look up identifier s exactly, the host sets the identifier register to s-1, issues get-next, and accepts the result only when the returned identifier equals s and the presence bit is set.

Top module: `stt_table`

## Requirements
- R1: After reset every register reads zero (identifier, operation, presence, both data words) and no record is present, so a get-next from identifier 0 returns identifier 63 with presence clear.
- R2: The identifier register (address 0) keeps only bits 5:0 of a write; bits 15:6 read back as zero.
- R3: Writing the operation register (address 1) with bit 15 set and opcode bits 14:12 = 3'b011 (load/purge) while the presence register (address 2, bit 0) is 1 stores the data-word states into the record named by the identifier register. Bit 15 of the operation register reads 1 for exactly one cycle.
- R4: Load/purge with presence bit 0 removes the record, so get-next no longer returns it.
- R5: Get-next (opcode 3'b101) returns the lowest present identifier strictly greater than the identifier register. It writes that identifier to the identifier register, sets the presence bit, and loads the record into the data words. Port i occupies data word i/8 (address 3 for word 0, address 4 for word 1) at bits (i%8)*2+1:(i%8)*2.
- R6: When no higher record is present, get-next sets the identifier register to 63, clears the presence bit, and leaves both data words unchanged.
- R7: Get-next keeps bit 15 of the operation register set for (f - s) cycles on a hit at identifier f from start identifier s, and for (64 - s) cycles on a miss.
- R8: Register writes arriving while busy is set are ignored.
- R9: Data-word bit pairs belonging to port numbers at or above NPORTS always read zero, whether written by the host or by get-next.
- R10: An exact lookup of s through identifier s-1 and get-next returns identifier s with presence set when s is present, and another identifier or presence clear when it is not.
- R11: An operation-register write with bit 15 clear, or with an opcode other than 3'b011 or 3'b101, starts nothing. Busy stays clear, the table is unchanged, and opcode bits 14:12 keep the last accepted opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both write and read (0 identifier, 1 operation, 2 presence, 3 data word 0, 4 data word 1) |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Combinational read data of the register at addr |

## Verification
Register writes take effect at the clock edge that samples them and are read back at the next falling edge. Load/purge clears busy one edge after the operation write. Get-next clears busy (f - s) edges after the write on a hit and (64 - s) edges after it on a miss. The operation task counts falling edges until bit 15 drops and compares that count with the figure computed from the identifiers involved. The identifier, presence and data words are pushed to the scoreboard only after busy has cleared, so every compared value is a settled result.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    A_SID  = 3'd0,
    A_OP   = 3'd1,
    A_VLD  = 3'd2,
    A_DAT0 = 3'd3,
    A_DAT1 = 3'd4
  } reg_addr_e;

  localparam logic [2:0] OPC_LOAD = 3'b011;
  localparam logic [2:0] OPC_NEXT = 3'b101;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_SCAN
  } ctl_state_e;
endpackage

// File: rtl/stt_store.sv
module stt_store #(
  parameter int unsigned SID_W = 6,
  parameter int unsigned STW   = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SID_W-1:0] waddr,
  input  logic             wvalid,
  input  logic [STW-1:0]   wstate,
  input  logic [SID_W-1:0] raddr,
  output logic             rvalid,
  output logic [STW-1:0]   rstate
);
  localparam int unsigned ENTRIES = 1 << SID_W;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [STW-1:0]     st_q [ENTRIES];

  always_comb begin
    vld_d = vld_q;
    if (we) vld_d[waddr] = wvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (we && wvalid) st_q[waddr] <= wstate;
  end

  assign rvalid = vld_q[raddr];
  assign rstate = st_q[raddr];

  // R4: a purge leaves the addressed record absent
  assert_purge_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wvalid) |=> !vld_q[$past(waddr)]);
  // R3: a load marks the addressed record present
  assert_load_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wvalid) |=> vld_q[$past(waddr)]);
endmodule

// File: rtl/stt_scan.sv
module stt_scan #(
  parameter int unsigned SID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SID_W-1:0] start_sid,
  input  logic             ent_valid,
  output logic [SID_W-1:0] rd_idx,
  output logic             done,
  output logic             hit,
  output logic [SID_W-1:0] res_sid
);
  logic             active_q, active_d;
  logic [SID_W:0]   cur_q, cur_d;

  assign rd_idx  = cur_q[SID_W-1:0];
  assign hit     = active_q && !cur_q[SID_W] && ent_valid;
  assign done    = active_q && (cur_q[SID_W] || ent_valid);
  assign res_sid = hit ? cur_q[SID_W-1:0] : '1;

  always_comb begin
    active_d = active_q;
    cur_d    = cur_q;
    if (start) begin
      active_d = 1'b1;
      cur_d    = {1'b0, start_sid} + 1'b1;
    end else if (active_q) begin
      if (done) active_d = 1'b0;
      else      cur_d    = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cur_q    <= '0;
    end else begin
      active_q <= active_d;
      cur_q    <= cur_d;
    end
  end

  // R7: each cycle without a result advances the cursor by exactly one
  assert_cursor_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !done) |=> (active_q && cur_q == $past(cur_q) + 1'b1));
  // R6: a scan ends no later than one step past the top identifier
  assert_cursor_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cur_q <= (SID_W+1)'(1 << SID_W)));
endmodule

// File: rtl/stt_table.sv
module stt_table #(
  parameter int unsigned NPORTS = 11,
  parameter int unsigned SID_W  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  import stt_pkg::*;

  localparam int unsigned STW  = 2 * NPORTS;
  localparam int unsigned DW   = 2 * WORD_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  ctl_state_e       state_q, state_d;
  logic [SID_W-1:0] sid_q, sid_d;
  logic             vld_q, vld_d;
  logic [STW-1:0]   dat_q, dat_d;
  logic [2:0]       opc_q, opc_d;
  logic             busy, start_wr, go_load, go_next;
  logic             st_rvalid, scan_done, scan_hit;
  logic [STW-1:0]   st_rstate;
  logic [SID_W-1:0] scan_idx, scan_sid;
  logic [DW-1:0]    dat_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign busy     = (state_q != S_IDLE);
  assign start_wr = wr_en && !busy && (addr == A_OP) && wdata[15];
  assign go_load  = start_wr && (wdata[14:12] == OPC_LOAD);
  assign go_next  = start_wr && (wdata[14:12] == OPC_NEXT);

  always_comb begin
    state_d = state_q;
    sid_d   = sid_q;
    vld_d   = vld_q;
    dat_d   = dat_q;
    opc_d   = opc_q;
    case (state_q)
      S_IDLE: begin
        if (wr_en) begin
          if (addr == A_SID) sid_d = wdata[SID_W-1:0];
          if (addr == A_VLD) vld_d = wdata[0];
          for (int b = 0; b < STW; b++) begin
            if ((b < WORD_W) ? (addr == A_DAT0) : (addr == A_DAT1))
              dat_d[b] = wdata[b % WORD_W];
          end
        end
        if (go_load) begin
          state_d = S_LOAD;
          opc_d   = OPC_LOAD;
        end else if (go_next) begin
          state_d = S_SCAN;
          opc_d   = OPC_NEXT;
        end
      end
      S_LOAD: state_d = S_IDLE;
      S_SCAN: begin
        if (scan_done) begin
          state_d = S_IDLE;
          sid_d   = scan_sid;
          vld_d   = scan_hit;
          if (scan_hit) dat_d = st_rstate;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE;
      sid_q   <= '0;
      vld_q   <= 1'b0;
      dat_q   <= '0;
      opc_q   <= '0;
    end else begin
      state_q <= state_d;
      sid_q   <= sid_d;
      vld_q   <= vld_d;
      dat_q   <= dat_d;
      opc_q   <= opc_d;
    end
  end

  stt_store #(.SID_W(SID_W), .STW(STW)) u_store (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (state_q == S_LOAD),
    .waddr  (sid_q),
    .wvalid (vld_q),
    .wstate (dat_q),
    .raddr  (scan_idx),
    .rvalid (st_rvalid),
    .rstate (st_rstate)
  );

  stt_scan #(.SID_W(SID_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (go_next),
    .start_sid (sid_q),
    .ent_valid (st_rvalid),
    .rd_idx    (scan_idx),
    .done      (scan_done),
    .hit       (scan_hit),
    .res_sid   (scan_sid)
  );

  always_comb begin
    dat_ext            = '0;
    dat_ext[STW-1:0]   = dat_q;
    rdata              = '0;
    case (addr)
      A_SID:   rdata[SID_W-1:0] = sid_q;
      A_OP:    rdata = {busy, opc_q, 12'h000};
      A_VLD:   rdata[0] = vld_q;
      A_DAT0:  rdata = dat_ext[WORD_W-1:0];
      A_DAT1:  rdata = dat_ext[DW-1:WORD_W];
      default: rdata = '0;
    endcase
  end

  // R3: load/purge holds busy for exactly one cycle
  assert_load_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(busy) && state_q == S_LOAD) |=> !busy);
  // R6: a scan without a result leaves identifier all-ones and presence clear
  assert_miss_result_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (scan_done && !scan_hit) |=> (sid_q == '1 && !vld_q && $stable(dat_q)));
  // R5: a scan result is a present record above the start identifier
  assert_hit_above_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (scan_done && scan_hit) |=> (vld_q && sid_q > $past(sid_q)));
  // R8: host writes do not disturb registers while busy
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !scan_done) |=> ($stable(sid_q) && $stable(dat_q) && $stable(vld_q)));
endmodule

// File: tb/stt_table_bench.sv
module stt_table_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  typedef struct {
    string       tag;
    logic [15:0] exp;
  } item_t;

  item_t sb[$];
  event  smp;

  always #10 clk = ~clk;

  stt_table u_stt_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the oldest expected item and compares with the read port
  initial begin
    forever begin
      @(smp);
      #1;
      begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, int'(rdata), int'(it.exp));
      end
    end
  end

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [15:0] e);
    item_t it;
    @(negedge clk);
    addr = a;
    it.tag = tag;
    it.exp = e;
    sb.push_back(it);
    -> smp;
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_op(input logic [2:0] opc);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = 3'd1;
    wdata = {1'b1, opc, 12'h000};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] opc, input int exp_cyc, input string tag);
    int cyc;
    start_op(opc);
    addr = 3'd1;
    cyc = 0;
    while (rdata[15] && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(tag, cyc, exp_cyc);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    addr = 3'd1;
    while (rdata[15]) @(negedge clk);
  endtask

  task automatic expect_result(input string tag, input logic [15:0] sid, input logic [15:0] v,
                               input logic [15:0] d0, input logic [15:0] d1);
    expect_reg({tag, " sid"}, 3'd0, sid);
    expect_reg({tag, " vld"}, 3'd2, v);
    expect_reg({tag, " d0"},  3'd3, d0);
    expect_reg({tag, " d1"},  3'd4, d1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    expect_reg("R1 sid", 3'd0, 16'h0000);
    expect_reg("R1 op",  3'd1, 16'h0000);
    expect_reg("R1 vld", 3'd2, 16'h0000);
    expect_reg("R1 d0",  3'd3, 16'h0000);
    expect_reg("R1 d1",  3'd4, 16'h0000);
    run_op(3'b101, 64, "R1 empty scan cycles");
    expect_result("R1 empty scan", 16'h003F, 16'h0000, 16'h0000, 16'h0000);

    // R2: identifier masking
    wr(3'd0, 16'hFFC5);
    expect_reg("R2 sid mask", 3'd0, 16'h0005);

    // R3 / R9: loads
    wr(3'd2, 16'h0001);
    wr(3'd3, 16'hE4A1);
    wr(3'd4, 16'hFFFF);
    expect_reg("R9 host write d1", 3'd4, 16'h003F);
    run_op(3'b011, 1, "R3 load 5 busy");
    wr(3'd0, 16'd20);
    wr(3'd3, 16'h1B1B);
    wr(3'd4, 16'h0015);
    run_op(3'b011, 1, "R3 load 20 busy");
    wr(3'd0, 16'd40);
    wr(3'd3, 16'h0003);
    wr(3'd4, 16'h0000);
    run_op(3'b011, 1, "R3 load 40 busy");
    // R4: purge 40
    wr(3'd2, 16'h0000);
    run_op(3'b011, 1, "R4 purge busy");

    // R5 / R7: ascending walk
    wr(3'd0, 16'h0000);
    run_op(3'b101, 5, "R7 hit 5 cycles");
    expect_result("R5 hit 5", 16'd5, 16'h0001, 16'hE4A1, 16'h003F);
    run_op(3'b101, 15, "R7 hit 20 cycles");
    expect_result("R5 hit 20", 16'd20, 16'h0001, 16'h1B1B, 16'h0015);
    run_op(3'b101, 44, "R7 miss cycles");
    expect_result("R6 R4 miss after purge", 16'h003F, 16'h0000, 16'h1B1B, 16'h0015);

    // R10: exact lookups
    wr(3'd0, 16'd19);
    run_op(3'b101, 1, "R10 lookup 20 cycles");
    expect_reg("R10 lookup 20 sid", 3'd0, 16'd20);
    expect_reg("R10 lookup 20 vld", 3'd2, 16'h0001);
    wr(3'd0, 16'd39);
    run_op(3'b101, 25, "R10 lookup 40 cycles");
    expect_reg("R10 lookup 40 sid", 3'd0, 16'h003F);
    expect_reg("R10 lookup 40 vld", 3'd2, 16'h0000);

    // R8: writes while busy
    wr(3'd0, 16'd21);
    start_op(3'b101);
    wr(3'd3, 16'h1234);
    wr(3'd0, 16'd7);
    wr(3'd2, 16'h0001);
    wr(3'd1, 16'hB000);
    wait_idle();
    expect_result("R8 busy writes", 16'h003F, 16'h0000, 16'h1B1B, 16'h0015);

    // R11: non-starting operation writes
    wr(3'd1, 16'h3000);
    expect_reg("R11 no start bit", 3'd1, 16'h5000);
    wr(3'd1, 16'hF000);
    expect_reg("R11 bad opcode", 3'd1, 16'h5000);
    wr(3'd0, 16'd4);
    run_op(3'b101, 1, "R11 table intact cycles");
    expect_result("R11 table intact", 16'd5, 16'h0001, 16'hE4A1, 16'h003F);

    // R3 / R7 at the top identifier
    wr(3'd0, 16'd63);
    wr(3'd2, 16'h0001);
    wr(3'd3, 16'h0C30);
    wr(3'd4, 16'h0001);
    run_op(3'b011, 1, "R3 load 63 busy");
    wr(3'd0, 16'd62);
    run_op(3'b101, 1, "R7 hit 63 cycles");
    expect_result("R5 hit 63", 16'h003F, 16'h0001, 16'h0C30, 16'h0001);
    run_op(3'b101, 1, "R7 scan from 63 cycles");
    expect_result("R6 scan from 63", 16'h003F, 16'h0000, 16'h0C30, 16'h0001);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule